// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block decides, cycle by cycle, whether a hart must stop normal execution and switch into debug mode, and it records the reason. Four sources can ask for entry: an executed ebreak (tagged with the privilege level it ran at), a fired hardware trigger, a halt request from the external debug module, and the end of a single-stepped instruction (either a normal retire or an exception). When more than one source is active in the same cycle, a fixed priority picks one. The winner's 3-bit code goes into a cause field, and the current privilege is saved.

The block also holds the rest of the debug control/status word: per-privilege ebreak enables, a stop-count bit, a step bit, the cause and the saved privilege. From these it drives a counter-inhibit output and an interrupt mask for the core. On a resume request it leaves debug mode and presents the saved privilege, which the core restores. All pins are plain level or pulse control signals. No data stream passes through the block, so no valid/ready handshake is used and nothing can be back-pressured. Every output is registered, so each reaction appears one clock after the input that caused it.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: After reset, the block is outside debug mode and all pulse outputs are low. The control word reads zero except the privilege field (bits 1:0), which reads 3 (machine).
- R2: An ebreak whose privilege has its enable bit set enters debug mode one cycle later. A `dbg_enter_o` pulse and `in_debug_o` rise together, the cause field (bits 8:6) reads 1 and the privilege field holds `cur_priv_i`. The enable bits are machine 15, hypervisor 14, supervisor 13 and user 12. The privilege codes are user 0, supervisor 1, hypervisor 2 and machine 3.
- R3: An ebreak whose privilege enable bit is clear does not enter debug mode. Instead it gives a one-cycle `ebrk_exc_o` pulse one cycle later.
- R4: A trigger fire enters debug mode one cycle later with cause 2.
- R5: A halt request enters debug mode one cycle later with cause 3.
- R6: With the step bit (bit 2) set and the block outside debug mode, an instruction retire enters debug mode one cycle later with cause 4. `irq_mask_o` is high whenever the step bit is set.
- R7: With the step bit set, an exception event also enters debug mode one cycle later with cause 4, ahead of the trap handler. A disabled ebreak during a step gives no `ebrk_exc_o` pulse.
- R8: Reasons that arrive in the same cycle are resolved in this order: trigger (2) first, then ebreak (1), then halt (3), then step (4).
- R9: While in debug mode no entry is recognised. The cause field changes only on an entry cycle.
- R10: `cnt_inhibit_o` is high exactly when the block is in debug mode and the stop-count bit (bit 10) is set.
- R11: Control-word writes take effect only while in debug mode. The cause field is never changed by a write.
- R12: A write whose privilege field names a level missing from `SUPPORTED_PRIV` leaves the privilege field unchanged. The default mask excludes hypervisor (2). The other fields of that write still apply.
- R13: A resume request while in debug mode drops `in_debug_o` one cycle later together with a one-cycle `resume_go_o` pulse. `resume_priv_o` equals the privilege field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ebrk_valid_i | input | 1 | An ebreak executed this cycle |
| cur_priv_i | input | 2 | Current privilege level of the hart |
| trig_fire_i | input | 1 | Trigger requests debug entry |
| halt_req_i | input | 1 | Halt request from the debug module |
| retire_i | input | 1 | An instruction retired this cycle |
| exc_i | input | 1 | An exception was taken this cycle |
| resume_req_i | input | 1 | Resume request |
| ctl_wr_en_i | input | 1 | Write strobe for the control word |
| ctl_wr_data_i | input | DATA_W | Control word write value |
| ctl_rd_data_o | output | DATA_W | Control word read value |
| dbg_enter_o | output | 1 | One-cycle pulse on debug entry |
| in_debug_o | output | 1 | Hart is in debug mode |
| ebrk_exc_o | output | 1 | One-cycle pulse: ordinary breakpoint exception |
| resume_go_o | output | 1 | One-cycle pulse on leaving debug mode |
| resume_priv_o | output | 2 | Privilege to restore on resume |
| cnt_inhibit_o | output | 1 | Stop cycle and instret counters |
| irq_mask_o | output | 1 | Mask interrupts while stepping |

## Verification
Any corrupted internal state reaches the ports within one clock, because every output is registered and the whole control word can be read back at all times. A wrong priority choice or a lost capture shows up in the cause and privilege bits right after the `dbg_enter_o` pulse. A stuck mode flag shows up on `in_debug_o`, `cnt_inhibit_o` or a missing pulse on the next edge. Writes that slip through outside debug mode appear in the read-back value on the following cycle. For these reasons, a reference model compared on every clock catches a deviation in the same cycle it becomes visible.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

  localparam int PRIV_W      = 2;
  localparam int NUM_PRIV    = 1 << PRIV_W;
  localparam int CAUSE_W     = 3;
  localparam int NUM_REASONS = 4;

  // control word field positions
  localparam int BIT_PRV_LO   = 0;
  localparam int BIT_STEP     = 2;
  localparam int BIT_CAUSE_LO = 6;
  localparam int BIT_STOPCNT  = 10;
  localparam int BIT_EBRK_LO  = 12;
  localparam int USED_MSB     = BIT_EBRK_LO + NUM_PRIV - 1;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_EBREAK  = 3'd1,
    CAUSE_TRIGGER = 3'd2,
    CAUSE_HALTREQ = 3'd3,
    CAUSE_STEP    = 3'd4
  } cause_e;

  typedef enum logic [PRIV_W-1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_H = 2'd2,
    PRIV_M = 2'd3
  } priv_e;

  // reason index: a higher index wins
  localparam int RSN_STEP = 0;
  localparam int RSN_HALT = 1;
  localparam int RSN_EBRK = 2;
  localparam int RSN_TRIG = 3;

  typedef struct packed {
    logic [NUM_PRIV-1:0] ebrk_en;  // indexed by privilege code
    logic                stopcnt;
    logic                step;
    cause_e              cause;
    priv_e               prv;
  } ctl_fields_t;

  function automatic cause_e cause_of(input int idx);
    case (idx)
      RSN_TRIG: cause_of = CAUSE_TRIGGER;
      RSN_EBRK: cause_of = CAUSE_EBREAK;
      RSN_HALT: cause_of = CAUSE_HALTREQ;
      RSN_STEP: cause_of = CAUSE_STEP;
      default:  cause_of = CAUSE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/dbg_reason_gen.sv
module dbg_reason_gen
  import dbg_entry_pkg::*;
(
  input  logic                   ebrk_valid_i,
  input  logic [PRIV_W-1:0]      cur_priv_i,
  input  logic                   trig_fire_i,
  input  logic                   halt_req_i,
  input  logic                   retire_i,
  input  logic                   exc_i,
  input  logic [NUM_PRIV-1:0]    ebrk_en_i,
  input  logic                   step_i,
  input  logic                   in_debug_i,
  output logic [NUM_REASONS-1:0] req_o,
  output logic                   ebrk_plain_o
);

  logic running;
  logic ebrk_enabled;
  logic step_done;

  assign running      = ~in_debug_i;
  assign ebrk_enabled = ebrk_en_i[cur_priv_i];
  // a stepped instruction ends on a retire or on a faulting attempt
  assign step_done    = step_i & (retire_i | exc_i);

  always_comb begin
    req_o           = '0;
    req_o[RSN_TRIG] = running & trig_fire_i;
    req_o[RSN_EBRK] = running & ebrk_valid_i & ebrk_enabled;
    req_o[RSN_HALT] = running & halt_req_i;
    req_o[RSN_STEP] = running & step_done;
  end

  assign ebrk_plain_o = running & ebrk_valid_i & ~ebrk_enabled;

endmodule

// File: rtl/dbg_reason_arb.sv
module dbg_reason_arb
  import dbg_entry_pkg::*;
#(
  parameter int N = NUM_REASONS
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o,
  output cause_e       cause_o
);

  generate
    for (genvar i = 0; i < N; i++) begin : g_gnt
      if (i == N - 1) begin : g_top
        assign gnt_o[i] = req_i[i];
      end else begin : g_low
        assign gnt_o[i] = req_i[i] & ~(|req_i[N-1:i+1]);
      end
    end
  endgenerate

  assign any_o = |req_i;

  always_comb begin
    cause_o = CAUSE_NONE;
    for (int i = 0; i < N; i++) begin
      if (gnt_o[i]) cause_o = cause_of(i);
    end
  end

endmodule

// File: rtl/dbg_ctl_regs.sv
module dbg_ctl_regs
  import dbg_entry_pkg::*;
#(
  parameter int                  DATA_W         = 32,
  parameter logic [NUM_PRIV-1:0] SUPPORTED_PRIV = 4'b1011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_debug_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              cap_i,
  input  cause_e            cap_cause_i,
  input  priv_e             cap_priv_i,
  output ctl_fields_t       fields_o,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam int TOP_PAD = DATA_W - USED_MSB - 1;

  ctl_fields_t         q;
  logic                wr_ok;
  logic [PRIV_W-1:0]   wr_prv;
  logic                unused_wr;

  assign wr_ok  = in_debug_i & wr_en_i;
  assign wr_prv = wr_data_i[BIT_PRV_LO +: PRIV_W];
  assign unused_wr = ^{wr_data_i[DATA_W-1:USED_MSB+1],
                       wr_data_i[BIT_EBRK_LO-1:BIT_STOPCNT+1],
                       wr_data_i[BIT_STOPCNT-1:BIT_STEP+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.ebrk_en <= '0;
      q.stopcnt <= 1'b0;
      q.step    <= 1'b0;
      q.cause   <= CAUSE_NONE;
      q.prv     <= PRIV_M;
    end else if (cap_i) begin
      q.cause <= cap_cause_i;
      q.prv   <= cap_priv_i;
    end else if (wr_ok) begin
      q.ebrk_en <= wr_data_i[BIT_EBRK_LO +: NUM_PRIV];
      q.stopcnt <= wr_data_i[BIT_STOPCNT];
      q.step    <= wr_data_i[BIT_STEP];
      if (SUPPORTED_PRIV[wr_prv]) q.prv <= priv_e'(wr_prv);
    end
  end

  assign fields_o = q;

  always_comb begin
    rd_data_o                              = '0;
    rd_data_o[BIT_EBRK_LO +: NUM_PRIV]     = q.ebrk_en;
    rd_data_o[BIT_STOPCNT]                 = q.stopcnt;
    rd_data_o[BIT_CAUSE_LO +: CAUSE_W]     = q.cause;
    rd_data_o[BIT_STEP]                    = q.step;
    rd_data_o[BIT_PRV_LO +: PRIV_W]        = q.prv;
    if (TOP_PAD < 0) rd_data_o = 'x;
  end

endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_i,
  input  logic resume_req_i,
  output logic in_debug_o,
  output logic enter_pulse_o,
  output logic resume_pulse_o
);

  logic go_in;
  logic go_out;

  assign go_in  = enter_i & ~in_debug_o;
  assign go_out = resume_req_i & in_debug_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_debug_o     <= 1'b0;
      enter_pulse_o  <= 1'b0;
      resume_pulse_o <= 1'b0;
    end else begin
      enter_pulse_o  <= go_in;
      resume_pulse_o <= go_out;
      if (go_in)       in_debug_o <= 1'b1;
      else if (go_out) in_debug_o <= 1'b0;
    end
  end

endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dbg_entry_pkg::*;
#(
  parameter int                  DATA_W         = 32,
  parameter logic [NUM_PRIV-1:0] SUPPORTED_PRIV = 4'b1011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ebrk_valid_i,
  input  logic [1:0]        cur_priv_i,
  input  logic              trig_fire_i,
  input  logic              halt_req_i,
  input  logic              retire_i,
  input  logic              exc_i,
  input  logic              resume_req_i,
  input  logic              ctl_wr_en_i,
  input  logic [DATA_W-1:0] ctl_wr_data_i,
  output logic [DATA_W-1:0] ctl_rd_data_o,
  output logic              dbg_enter_o,
  output logic              in_debug_o,
  output logic              ebrk_exc_o,
  output logic              resume_go_o,
  output logic [1:0]        resume_priv_o,
  output logic              cnt_inhibit_o,
  output logic              irq_mask_o
);

  logic [NUM_REASONS-1:0] req;
  logic [NUM_REASONS-1:0] gnt;
  logic                   any_req;
  logic                   ebrk_plain;
  cause_e                 win_cause;
  ctl_fields_t            fields;
  logic                   in_dbg;
  logic                   ebrk_exc_q;
  logic                   unused_gnt;

  assign unused_gnt = ^gnt;

  dbg_reason_gen u_gen (
    .ebrk_valid_i (ebrk_valid_i),
    .cur_priv_i   (cur_priv_i),
    .trig_fire_i  (trig_fire_i),
    .halt_req_i   (halt_req_i),
    .retire_i     (retire_i),
    .exc_i        (exc_i),
    .ebrk_en_i    (fields.ebrk_en),
    .step_i       (fields.step),
    .in_debug_i   (in_dbg),
    .req_o        (req),
    .ebrk_plain_o (ebrk_plain)
  );

  dbg_reason_arb #(.N(NUM_REASONS)) u_arb (
    .req_i   (req),
    .gnt_o   (gnt),
    .any_o   (any_req),
    .cause_o (win_cause)
  );

  dbg_ctl_regs #(
    .DATA_W         (DATA_W),
    .SUPPORTED_PRIV (SUPPORTED_PRIV)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_debug_i  (in_dbg),
    .wr_en_i     (ctl_wr_en_i),
    .wr_data_i   (ctl_wr_data_i),
    .cap_i       (any_req),
    .cap_cause_i (win_cause),
    .cap_priv_i  (priv_e'(cur_priv_i)),
    .fields_o    (fields),
    .rd_data_o   (ctl_rd_data_o)
  );

  dbg_mode_ctrl u_mode (
    .clk            (clk),
    .rst_n          (rst_n),
    .enter_i        (any_req),
    .resume_req_i   (resume_req_i),
    .in_debug_o     (in_dbg),
    .enter_pulse_o  (dbg_enter_o),
    .resume_pulse_o (resume_go_o)
  );

  // a disabled ebreak becomes an ordinary exception unless entry wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ebrk_exc_q <= 1'b0;
    else        ebrk_exc_q <= ebrk_plain & ~any_req;
  end

  assign in_debug_o    = in_dbg;
  assign ebrk_exc_o    = ebrk_exc_q;
  assign resume_priv_o = fields.prv;
  assign cnt_inhibit_o = in_dbg & fields.stopcnt;
  assign irq_mask_o    = fields.step;

endmodule

// File: rtl/dbg_entry_ctrl_chk.sv
module dbg_entry_ctrl_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] ctl_rd_data_o,
  input logic              dbg_enter_o,
  input logic              in_debug_o,
  input logic              ebrk_exc_o,
  input logic              resume_go_o,
  input logic              cnt_inhibit_o
);

  // R9
  enter_sets_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_enter_o |-> in_debug_o);

  // R9
  no_reentry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_debug_o) |-> !dbg_enter_o);

  // R9
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_enter_o |-> $stable(ctl_rd_data_o[8:6]));

  // R2
  cause_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_enter_o |-> (ctl_rd_data_o[8:6] >= 3'd1 && ctl_rd_data_o[8:6] <= 3'd4));

  // R10
  inhibit_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_inhibit_o |-> in_debug_o);

  // R3
  exc_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ebrk_exc_o |-> (!dbg_enter_o && !in_debug_o));

  // R13
  resume_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_go_o |-> (!in_debug_o && $past(in_debug_o)));

endmodule

bind dbg_entry_ctrl dbg_entry_ctrl_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_dbg_entry_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_entry_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ebrk_valid = 0, trig = 0, halt = 0, retire = 0, exc = 0, resume = 0, wr_en = 0;
  logic [1:0]  cur_priv = 2'd3;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        enter, in_dbg, ebrk_exc, resume_go, cnt_inh, irq_mask;
  logic [1:0]  resume_priv;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  dbg_entry_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ebrk_valid_i(ebrk_valid), .cur_priv_i(cur_priv),
    .trig_fire_i(trig), .halt_req_i(halt), .retire_i(retire), .exc_i(exc),
    .resume_req_i(resume), .ctl_wr_en_i(wr_en), .ctl_wr_data_i(wr_data),
    .ctl_rd_data_o(rd_data), .dbg_enter_o(enter), .in_debug_o(in_dbg),
    .ebrk_exc_o(ebrk_exc), .resume_go_o(resume_go), .resume_priv_o(resume_priv),
    .cnt_inhibit_o(cnt_inh), .irq_mask_o(irq_mask)
  );

  // behavioural reference model
  bit       m_dbg, m_enter, m_exc, m_res, m_stop, m_step;
  bit [3:0] m_en;
  bit [2:0] m_cause;
  bit [1:0] m_prv;

  always @(posedge clk) begin
    int  c;
    bit  ok, ent;
    if (!rst_n) begin
      m_dbg = 0; m_enter = 0; m_exc = 0; m_res = 0; m_stop = 0; m_step = 0;
      m_en = 0; m_cause = 0; m_prv = 3;
    end else begin
      ok = ebrk_valid && m_en[cur_priv];
      c = 0;
      if (!m_dbg) begin
        if (trig) c = 2;
        else if (ok) c = 1;
        else if (halt) c = 3;
        else if (m_step && (retire || exc)) c = 4;
      end
      ent = (c != 0);
      m_exc = !m_dbg && ebrk_valid && !m_en[cur_priv] && !ent;
      m_res = m_dbg && resume;
      m_enter = ent;
      if (ent) begin
        m_cause = 3'(c); m_prv = cur_priv; m_dbg = 1;
      end else begin
        if (m_dbg && wr_en) begin
          m_en = wr_data[15:12]; m_stop = wr_data[10]; m_step = wr_data[2];
          if (wr_data[1:0] != 2'd2) m_prv = wr_data[1:0];
        end
        if (m_res) m_dbg = 0;
      end
    end
  end

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!done) begin
      cmp("dbg_enter", 32'(enter), 32'(m_enter));
      cmp("in_debug", 32'(in_dbg), 32'(m_dbg));
      cmp("ebrk_exc", 32'(ebrk_exc), 32'(m_exc));
      cmp("resume_go", 32'(resume_go), 32'(m_res));
      cmp("resume_priv", 32'(resume_priv), 32'(m_prv));
      cmp("cnt_inhibit", 32'(cnt_inh), 32'(m_dbg && m_stop));
      cmp("irq_mask", 32'(irq_mask), 32'(m_step));
      cmp("ctl_word", rd_data, {16'b0, m_en, 1'b0, m_stop, 1'b0, m_cause, 3'b0, m_step, m_prv});
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    ebrk_valid = 0; trig = 0; halt = 0; retire = 0; exc = 0; resume = 0; wr_en = 0;
  endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1; wr_data = d; tick(); wr_en = 0; tick();
  endtask

  task automatic do_resume();
    resume = 1; tick(); resume = 0; tick(2);
  endtask

  initial begin
    tick(3);
    cur_req = "R1";
    rst_n = 1; tick(2);

    cur_req = "R11";              // write outside debug is ignored
    wr(32'h0000_f406); tick();

    cur_req = "R5";               // halt request
    cur_priv = 2'd1; halt = 1; tick(); halt = 0; tick(2);

    cur_req = "R12";              // hypervisor level unsupported
    wr(32'h0000_9402);            // M and U enabled, stop-count, prv=2
    cur_req = "R11";              // cause bits written with 7 are ignored
    wr(32'h0000_95c1);            // prv=1
    cur_req = "R10";
    tick(2);

    cur_req = "R9";               // no entry while in debug
    trig = 1; halt = 1; ebrk_valid = 1; tick(2); clr(); tick();

    cur_req = "R13";
    do_resume();

    cur_req = "R2";               // ebreak enabled at machine level
    cur_priv = 2'd3; ebrk_valid = 1; tick(); clr(); tick(2);
    do_resume();
    cur_priv = 2'd0; ebrk_valid = 1; tick(); clr(); tick(2);
    do_resume();

    cur_req = "R3";               // supervisor ebreak disabled
    cur_priv = 2'd1; ebrk_valid = 1; tick(); clr(); tick(2);

    cur_req = "R4";
    trig = 1; tick(); clr(); tick(2);
    do_resume();

    cur_req = "R8";
    cur_priv = 2'd3;
    trig = 1; ebrk_valid = 1; halt = 1; tick(); clr(); tick(); do_resume();
    ebrk_valid = 1; halt = 1; tick(); clr(); tick(); do_resume();
    halt = 1; trig = 1; tick(); clr(); tick(); do_resume();

    cur_req = "R6";               // enable step then resume
    halt = 1; tick(); clr(); tick();
    wr(32'h0000_9007);
    do_resume();
    tick(2);
    retire = 1; tick(); clr(); tick(2);
    cur_req = "R8";               // halt beats step
    do_resume();
    halt = 1; retire = 1; tick(); clr(); tick(); do_resume();

    cur_req = "R7";               // faulting step
    exc = 1; tick(); clr(); tick(); do_resume();
    cur_priv = 2'd1; ebrk_valid = 1; exc = 1; tick(); clr(); tick(); do_resume();

    cur_req = "R6";               // clear step, retire has no effect
    cur_priv = 2'd3; halt = 1; tick(); clr(); tick();
    wr(32'h0000_8003);
    do_resume();
    retire = 1; exc = 1; tick(); clr(); tick(3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule